// File: doc/BRIEF.md
# Sum-of-Products Logic Cell

The block is a behavioural model of one logic cell of a sum-of-products programmable device. Static configuration inputs give each of five product terms its own pair of literal masks. One mask selects sources that must be high and the other selects sources that must be low. The sources are the routed input vector and a 16-wide foldback bus. A role code per term sends the term into the OR sum, into the second XOR operand, or into a control function: storage clock, clock enable, preset, clear or output enable. A chain input lets neighbouring cells extend the sum.

The XOR stage sets output polarity. It can also fold the stored bit back into the data path, so that a D storage element behaves as a toggle element. The storage element works as a D flip-flop, a T flip-flop or a transparent latch. Its clock comes from one of three global clock lines or from the clock-role terms. The pin value is either the combinational XOR result or the stored bit. The output enable comes from six global lines, from the enable-role terms, or is held on. The cell also drives the inverse of one chosen term back onto the foldback bus.

All cell signals are sampled by the system clock `clk`. A rising edge of the selected storage clock is detected between two consecutive `clk` samples. Preset and clear act on the outputs in the same cycle.

Top module: `pld_macrocell`

## Requirements
- R1: Term t is the AND of source s for every set bit `cfg_lit_true[t][s]` and of the inverse of source s for every set bit `cfg_lit_comp[t][s]`. The sources are `{fold_bus, src_in}`, with `src_in[0]` at source index 0 and `fold_bus[0]` at index N_IN. A term with no mask bits set is 1.
- R2: The sum is the OR of all terms whose role is SUM and of `chain_in`. When no term is SUM and `chain_in` is 0, the sum is 0.
- R3: `chain_out` equals the sum when `cfg_chain_en` is 1, and is 0 when `cfg_chain_en` is 0.
- R4: The combinational result is the sum XOR an operand chosen by `cfg_xor_sel`: 0 gives constant 0, 1 gives constant 1, 2 gives the OR of XOR-role terms, and 3 gives the stored bit.
- R5: `fold_out` is the inverse of the term indexed by `cfg_fb_sel`. Index values of N_PT and above give 1.
- R6: `cfg_store_mode` selects the storage behaviour. Values 0 and 3 give a D flip-flop that loads the combinational result on a clock rise. Value 1 gives a T flip-flop that inverts the stored bit on a clock rise when the result is 1. Value 2 gives a latch that passes the result through, and keeps it, while the clock is high. Reset of the model clears the stored bit.
- R7: `cfg_ck_src` values 0 to N_GCK-1 select `gclk_lines[i]`, and larger values select the OR of CLK-role terms. A rise is a sample of 1 after a sample of 0. The stored value appears on the pin one `clk` cycle after the cycle that holds the rise. A clock that stays high loads nothing further.
- R8: The clock enable is the OR of CE-role terms, or 1 when no term has role CE. While the enable is 0, the D and T elements keep their value.
- R9: A clear is `clr_all` or any CLR-role term at 1. It forces the stored bit and the visible storage output to 0 in the same cycle. A SET-role term at 1 forces them to 1, and a clear wins over a preset.
- R10: `pin_o` is the visible storage output when `cfg_reg_out` is 1, and the combinational result otherwise. `cfg_oe_src` values 0 to 5 select `goe_lines[i]`, value 6 selects the OR of OE-role terms (0 if there are none), and value 7 holds `pin_oe` at 1.
- R11: The role codes are 0 SUM, 1 XOR, 2 CLK, 3 CE, 4 SET, 5 CLR, 6 OE and 7 unused. A term whose role is not SUM does not contribute to the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system sampling clock |
| rst_n | input | 1 | active-low model reset |
| src_in | input | N_IN | routed input signals |
| fold_bus | input | N_FB | regional foldback bus |
| chain_in | input | 1 | sum from the neighbouring cell |
| gclk_lines | input | N_GCK | global clock lines |
| goe_lines | input | N_GOE | global output-enable lines |
| clr_all | input | 1 | global clear |
| cfg_lit_true | input | N_PT x N_SRC | true-literal masks per term |
| cfg_lit_comp | input | N_PT x N_SRC | complement-literal masks per term |
| cfg_pt_role | input | N_PT x 3 | role code per term |
| cfg_xor_sel | input | 2 | XOR second operand select |
| cfg_store_mode | input | 2 | storage element kind |
| cfg_ck_src | input | CKW | storage clock source |
| cfg_oe_src | input | OEW | output-enable source |
| cfg_fb_sel | input | FBW | term driven inverted to foldback |
| cfg_reg_out | input | 1 | pin shows stored bit when 1 |
| cfg_chain_en | input | 1 | enables chain output |
| pin_o | output | 1 | pin data value |
| pin_oe | output | 1 | pin drive enable |
| chain_out | output | 1 | sum forwarded to next cell |
| fold_out | output | 1 | inverted term for foldback bus |

## Verification
The hardest state to reach from the ports is one where a term that also reacts to the data inputs drives the storage clock, enable, preset or clear. A rise, an enable and a preset can then coincide in the same cycle. Directed sequences first set each such role on a term with a single literal, step the literal with known stored values, and check that hold, load, toggle and priority each take effect in the right cycle. A long random phase follows. It uses sparse literal masks so that terms switch often, and a role mix biased toward SUM. Controls from terms therefore fire now and then, and a behavioural reference tracks each of these cycles.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [2:0] {
        ROLE_SUM = 3'd0,
        ROLE_XOR = 3'd1,
        ROLE_CLK = 3'd2,
        ROLE_CE  = 3'd3,
        ROLE_SET = 3'd4,
        ROLE_CLR = 3'd5,
        ROLE_OE  = 3'd6,
        ROLE_OFF = 3'd7
    } pt_role_e;

    typedef enum logic [1:0] {
        XOP_ZERO  = 2'd0,
        XOP_ONE   = 2'd1,
        XOP_TERM  = 2'd2,
        XOP_STATE = 2'd3
    } xor_op_e;

    typedef enum logic [1:0] {
        SM_DFF     = 2'd0,
        SM_TFF     = 2'd1,
        SM_LATCH   = 2'd2,
        SM_DFF_ALT = 2'd3
    } store_mode_e;

    // combined outputs of the term router
    typedef struct packed {
        logic sum;
        logic xor_term;
        logic clk_term;
        logic ce;
        logic set_term;
        logic clr_term;
        logic oe_term;
    } pt_ctrl_t;

    // registered state of the storage element
    typedef struct packed {
        logic stored;
        logic ck_prev;
    } store_state_t;

endpackage

// File: rtl/mc_pterm_array.sv
module mc_pterm_array #(
    parameter int N_SRC = 24,
    parameter int N_PT  = 5
) (
    input  logic [N_SRC-1:0]           src,
    input  logic [N_PT-1:0][N_SRC-1:0] lit_true,
    input  logic [N_PT-1:0][N_SRC-1:0] lit_comp,
    output logic [N_PT-1:0]            pt
);

    // one wide AND per term; an unselected literal contributes a 1
    for (genvar g = 0; g < N_PT; g++) begin : g_term
        logic [N_SRC-1:0] need_hi;
        logic [N_SRC-1:0] need_lo;
        assign need_hi = ~lit_true[g] | src;
        assign need_lo = ~lit_comp[g] | ~src;
        assign pt[g]   = &(need_hi & need_lo);
    end

endmodule

// File: rtl/mc_pt_router.sv
module mc_pt_router
    import mc_pkg::*;
#(
    parameter int N_PT = 5
) (
    input  logic [N_PT-1:0]      pt,
    input  logic [N_PT-1:0][2:0] role,
    output pt_ctrl_t             ctl
);

    logic ce_claimed;
    logic ce_or;

    always_comb begin
        ctl        = '0;
        ce_claimed = 1'b0;
        ce_or      = 1'b0;
        for (int i = 0; i < N_PT; i++) begin
            case (pt_role_e'(role[i]))
                ROLE_SUM: ctl.sum      = ctl.sum      | pt[i];
                ROLE_XOR: ctl.xor_term = ctl.xor_term | pt[i];
                ROLE_CLK: ctl.clk_term = ctl.clk_term | pt[i];
                ROLE_CE: begin
                    ce_claimed = 1'b1;
                    ce_or      = ce_or | pt[i];
                end
                ROLE_SET: ctl.set_term = ctl.set_term | pt[i];
                ROLE_CLR: ctl.clr_term = ctl.clr_term | pt[i];
                ROLE_OE:  ctl.oe_term  = ctl.oe_term  | pt[i];
                default:  ;
            endcase
        end
        // no enable term means always enabled
        ctl.ce = ce_claimed ? ce_or : 1'b1;
    end

endmodule

// File: rtl/mc_storage.sv
module mc_storage
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  store_mode_e mode,
    input  logic        ck_lvl,
    input  logic        ce,
    input  logic        set_lvl,
    input  logic        clr_lvl,
    input  logic        d_in,
    output logic        stored,
    output logic        q_vis
);

    store_state_t st_d;
    store_state_t st_q;
    logic         rise;
    logic         see_through;

    always_comb begin
        st_d         = st_q;
        st_d.ck_prev = ck_lvl;
        rise         = ck_lvl & ~st_q.ck_prev;
        see_through  = (mode == SM_LATCH) & ck_lvl & ce;

        case (mode)
            SM_TFF: begin
                if (rise && ce) st_d.stored = st_q.stored ^ d_in;
            end
            SM_LATCH: begin
                if (ck_lvl && ce) st_d.stored = d_in;
            end
            default: begin
                if (rise && ce) st_d.stored = d_in;
            end
        endcase

        if (clr_lvl)      st_d.stored = 1'b0;
        else if (set_lvl) st_d.stored = 1'b1;

        if (clr_lvl)          q_vis = 1'b0;
        else if (set_lvl)     q_vis = 1'b1;
        else if (see_through) q_vis = d_in;
        else                  q_vis = st_q.stored;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stored = st_q.stored;

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import mc_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_FB  = 16,
    parameter int N_PT  = 5,
    parameter int N_GCK = 3,
    parameter int N_GOE = 6,
    localparam int N_SRC = N_IN + N_FB,
    localparam int CKW   = $clog2(N_GCK + 1),
    localparam int OEW   = $clog2(N_GOE + 2),
    localparam int FBW   = $clog2(N_PT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_IN-1:0]            src_in,
    input  logic [N_FB-1:0]            fold_bus,
    input  logic                       chain_in,
    input  logic [N_GCK-1:0]           gclk_lines,
    input  logic [N_GOE-1:0]           goe_lines,
    input  logic                       clr_all,
    input  logic [N_PT-1:0][N_SRC-1:0] cfg_lit_true,
    input  logic [N_PT-1:0][N_SRC-1:0] cfg_lit_comp,
    input  logic [N_PT-1:0][2:0]       cfg_pt_role,
    input  logic [1:0]                 cfg_xor_sel,
    input  logic [1:0]                 cfg_store_mode,
    input  logic [CKW-1:0]             cfg_ck_src,
    input  logic [OEW-1:0]             cfg_oe_src,
    input  logic [FBW-1:0]             cfg_fb_sel,
    input  logic                       cfg_reg_out,
    input  logic                       cfg_chain_en,
    output logic                       pin_o,
    output logic                       pin_oe,
    output logic                       chain_out,
    output logic                       fold_out
);

    localparam logic [CKW-1:0] CK_TERM = CKW'(N_GCK);
    localparam logic [OEW-1:0] OE_TERM = OEW'(N_GOE);
    localparam logic [FBW-1:0] FB_LAST = FBW'(N_PT - 1);

    logic [N_SRC-1:0] src_all;
    logic [N_PT-1:0]  pt;
    pt_ctrl_t         ctl;
    logic             sum;
    logic             op2;
    logic             xor_res;
    logic             ck_lvl;
    logic             ce_lvl;
    logic             set_lvl;
    logic             clr_lvl;
    logic             stored;
    logic             q_vis;

    assign src_all = {fold_bus, src_in};

    mc_pterm_array #(.N_SRC(N_SRC), .N_PT(N_PT)) u_terms (
        .src      (src_all),
        .lit_true (cfg_lit_true),
        .lit_comp (cfg_lit_comp),
        .pt       (pt)
    );

    mc_pt_router #(.N_PT(N_PT)) u_route (
        .pt   (pt),
        .role (cfg_pt_role),
        .ctl  (ctl)
    );

    always_comb begin
        sum = ctl.sum | chain_in;

        case (xor_op_e'(cfg_xor_sel))
            XOP_ZERO:  op2 = 1'b0;
            XOP_ONE:   op2 = 1'b1;
            XOP_TERM:  op2 = ctl.xor_term;
            default:   op2 = stored;
        endcase
        xor_res = sum ^ op2;

        if (cfg_ck_src < CK_TERM) ck_lvl = gclk_lines[cfg_ck_src];
        else                      ck_lvl = ctl.clk_term;

        if (cfg_oe_src < OE_TERM)       pin_oe = goe_lines[cfg_oe_src];
        else if (cfg_oe_src == OE_TERM) pin_oe = ctl.oe_term;
        else                            pin_oe = 1'b1;

        if (cfg_fb_sel <= FB_LAST) fold_out = ~pt[cfg_fb_sel];
        else                       fold_out = 1'b1;

        ce_lvl    = ctl.ce;
        set_lvl   = ctl.set_term;
        clr_lvl   = ctl.clr_term | clr_all;
        chain_out = cfg_chain_en & sum;
        pin_o     = cfg_reg_out ? q_vis : xor_res;
    end

    mc_storage u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (store_mode_e'(cfg_store_mode)),
        .ck_lvl  (ck_lvl),
        .ce      (ce_lvl),
        .set_lvl (set_lvl),
        .clr_lvl (clr_lvl),
        .d_in    (xor_res),
        .stored  (stored),
        .q_vis   (q_vis)
    );

endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
    parameter int OEW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_reg_out,
    input logic           clr_all,
    input logic           cfg_chain_en,
    input logic           chain_in,
    input logic           chain_out,
    input logic [OEW-1:0] cfg_oe_src,
    input logic           pin_o,
    input logic           pin_oe,
    input logic           ce_lvl,
    input logic           set_lvl,
    input logic           clr_lvl,
    input logic [1:0]     cfg_store_mode,
    input logic           stored
);

    localparam logic [OEW-1:0] OE_ALL = '1;

    // R9: global clear forces the visible stored value low
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reg_out && clr_all) |-> !pin_o);

    // R3: chain output gated off
    assert_chain_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chain_en |-> !chain_out);

    // R2: chain input always reaches the sum
    assert_chain_feed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chain_en && chain_in) |-> chain_out);

    // R10: top output-enable code keeps the pin driven
    assert_oe_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_src == OE_ALL) |-> pin_oe);

    // R8: enable low holds edge-triggered storage
    assert_ce_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_lvl && !set_lvl && !clr_lvl && cfg_store_mode != 2'd2) |=> $stable(stored));

endmodule

bind pld_macrocell mc_checker #(.OEW(OEW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_reg_out    (cfg_reg_out),
    .clr_all        (clr_all),
    .cfg_chain_en   (cfg_chain_en),
    .chain_in       (chain_in),
    .chain_out      (chain_out),
    .cfg_oe_src     (cfg_oe_src),
    .pin_o          (pin_o),
    .pin_oe         (pin_oe),
    .ce_lvl         (ce_lvl),
    .set_lvl        (set_lvl),
    .clr_lvl        (clr_lvl),
    .cfg_store_mode (cfg_store_mode),
    .stored         (stored)
);

// File: tb/tb_pld_macrocell.sv
module tb_pld_macrocell;
    import mc_pkg::*;

    localparam int N_IN  = 8;
    localparam int N_FB  = 16;
    localparam int N_PT  = 5;
    localparam int N_GCK = 3;
    localparam int N_GOE = 6;
    localparam int N_SRC = N_IN + N_FB;
    localparam int CKW   = $clog2(N_GCK + 1);
    localparam int OEW   = $clog2(N_GOE + 2);
    localparam int FBW   = $clog2(N_PT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_IN-1:0]            src_in;
    logic [N_FB-1:0]            fold_bus;
    logic                       chain_in;
    logic [N_GCK-1:0]           gclk_lines;
    logic [N_GOE-1:0]           goe_lines;
    logic                       clr_all;
    logic [N_PT-1:0][N_SRC-1:0] cfg_lit_true;
    logic [N_PT-1:0][N_SRC-1:0] cfg_lit_comp;
    logic [N_PT-1:0][2:0]       cfg_pt_role;
    logic [1:0]                 cfg_xor_sel;
    logic [1:0]                 cfg_store_mode;
    logic [CKW-1:0]             cfg_ck_src;
    logic [OEW-1:0]             cfg_oe_src;
    logic [FBW-1:0]             cfg_fb_sel;
    logic                       cfg_reg_out;
    logic                       cfg_chain_en;
    logic pin_o, pin_oe, chain_out, fold_out;

    int checks = 0;
    int fails  = 0;
    logic m_state, m_prev, mn_state, mn_prev;

    always #5 clk = ~clk;

    pld_macrocell #(.N_IN(N_IN), .N_FB(N_FB), .N_PT(N_PT), .N_GCK(N_GCK), .N_GOE(N_GOE)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .fold_bus(fold_bus), .chain_in(chain_in),
        .gclk_lines(gclk_lines), .goe_lines(goe_lines), .clr_all(clr_all),
        .cfg_lit_true(cfg_lit_true), .cfg_lit_comp(cfg_lit_comp), .cfg_pt_role(cfg_pt_role),
        .cfg_xor_sel(cfg_xor_sel), .cfg_store_mode(cfg_store_mode), .cfg_ck_src(cfg_ck_src),
        .cfg_oe_src(cfg_oe_src), .cfg_fb_sel(cfg_fb_sel), .cfg_reg_out(cfg_reg_out),
        .cfg_chain_en(cfg_chain_en), .pin_o(pin_o), .pin_oe(pin_oe),
        .chain_out(chain_out), .fold_out(fold_out)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic fall();
        @(negedge clk);
    endtask

    task automatic defaults();
        src_in = '0; fold_bus = '0; chain_in = 1'b0; gclk_lines = '0; goe_lines = '0;
        clr_all = 1'b0; cfg_lit_true = '0; cfg_lit_comp = '0;
        for (int t = 0; t < N_PT; t++) cfg_pt_role[t] = ROLE_OFF;
        cfg_xor_sel = XOP_ZERO; cfg_store_mode = SM_DFF; cfg_ck_src = '0;
        cfg_oe_src = '1; cfg_fb_sel = '0; cfg_reg_out = 1'b0; cfg_chain_en = 1'b0;
    endtask

    // behavioural reference of one sampling cycle
    task automatic model_eval(output logic e_pin, output logic e_oe, output logic e_cas,
                              output logic e_fb, output logic n_state, output logic n_prev);
        logic [N_SRC-1:0] s;
        logic [N_PT-1:0]  term;
        logic sum, xt, ckt, cet, ceany, st, ct, ot, op, x, ck, rise, ce, q, nxt, clr;
        s = {fold_bus, src_in};
        for (int t = 0; t < N_PT; t++) begin
            term[t] = 1'b1;
            for (int k = 0; k < N_SRC; k++) begin
                if (cfg_lit_true[t][k] && !s[k]) term[t] = 1'b0;
                if (cfg_lit_comp[t][k] &&  s[k]) term[t] = 1'b0;
            end
        end
        sum = chain_in; xt = 0; ckt = 0; cet = 0; ceany = 0; st = 0; ct = 0; ot = 0;
        for (int t = 0; t < N_PT; t++) begin
            case (int'(cfg_pt_role[t]))
                0: sum = sum | term[t];
                1: xt  = xt  | term[t];
                2: ckt = ckt | term[t];
                3: begin cet = cet | term[t]; ceany = 1; end
                4: st  = st  | term[t];
                5: ct  = ct  | term[t];
                6: ot  = ot  | term[t];
                default: ;
            endcase
        end
        ce = ceany ? cet : 1'b1;
        case (int'(cfg_xor_sel))
            0: op = 0;
            1: op = 1;
            2: op = xt;
            default: op = m_state;
        endcase
        x    = sum ^ op;
        ck   = (int'(cfg_ck_src) < N_GCK) ? gclk_lines[cfg_ck_src] : ckt;
        rise = ck && !m_prev;
        nxt  = m_state;
        if (cfg_store_mode == 2'd1) begin
            if (rise && ce) nxt = m_state ^ x;
        end else if (cfg_store_mode == 2'd2) begin
            if (ck && ce) nxt = x;
        end else begin
            if (rise && ce) nxt = x;
        end
        clr = clr_all || ct;
        if (clr) nxt = 0; else if (st) nxt = 1;
        q = clr ? 1'b0 : st ? 1'b1 : (cfg_store_mode == 2'd2 && ck && ce) ? x : m_state;
        e_pin   = cfg_reg_out ? q : x;
        e_oe    = (int'(cfg_oe_src) < N_GOE) ? goe_lines[cfg_oe_src] :
                  (int'(cfg_oe_src) == N_GOE) ? ot : 1'b1;
        e_cas   = cfg_chain_en && sum;
        e_fb    = (int'(cfg_fb_sel) < N_PT) ? !term[cfg_fb_sel] : 1'b1;
        n_state = nxt;
        n_prev  = ck;
    endtask

    task automatic random_config();
        for (int t = 0; t < N_PT; t++) begin
            cfg_lit_true[t] = '0;
            cfg_lit_comp[t] = '0;
            repeat ($urandom % 3) begin
                int s = int'($urandom % N_SRC);
                if ($urandom % 2 == 0) cfg_lit_true[t][s] = 1'b1;
                else                   cfg_lit_comp[t][s] = 1'b1;
            end
            cfg_pt_role[t] = ($urandom % 2 == 0) ? 3'(ROLE_SUM) : 3'($urandom % 8);
        end
        cfg_xor_sel    = 2'($urandom);
        cfg_store_mode = 2'($urandom);
        cfg_ck_src     = CKW'($urandom);
        cfg_oe_src     = OEW'($urandom);
        cfg_fb_sel     = FBW'($urandom);
        cfg_reg_out    = 1'($urandom);
        cfg_chain_en   = 1'($urandom);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic e_pin, e_oe, e_cas, e_fb;
        defaults();
        cfg_reg_out = 1'b1;
        repeat (3) fall();
        rst_n = 1'b1; #1;
        chk("R6 reset leaves stored bit 0", pin_o, 1'b0);
        chk("R3 reset chain out", chain_out, 1'b0);

        // R1 literals
        fall(); defaults(); cfg_pt_role[0] = ROLE_SUM;
        cfg_lit_true[0][0] = 1'b1; cfg_lit_comp[0][1] = 1'b1; src_in = 8'h01; #1;
        chk("R1 both literals met", pin_o, 1'b1);
        fall(); src_in = 8'h03; #1;
        chk("R1 complement literal violated", pin_o, 1'b0);
        fall(); src_in = 8'h01; cfg_lit_true[0][N_IN+2] = 1'b1; #1;
        chk("R1 foldback literal low", pin_o, 1'b0);
        fall(); fold_bus = 16'h0004; #1;
        chk("R1 foldback literal high", pin_o, 1'b1);
        fall(); cfg_pt_role[0] = ROLE_CLK; #1;
        chk("R11 control-role term out of sum", pin_o, 1'b0);
        fall(); chain_in = 1'b1; #1;
        chk("R2 chain input joins sum", pin_o, 1'b1);
        fall(); cfg_chain_en = 1'b1; #1;
        chk("R3 chain out carries chain in", chain_out, 1'b1);
        fall(); chain_in = 1'b0; #1;
        chk("R2 empty sum is zero", chain_out, 1'b0);
        fall(); cfg_pt_role[0] = ROLE_SUM; #1;
        chk("R3 chain out carries term", chain_out, 1'b1);
        fall(); cfg_chain_en = 1'b0; #1;
        chk("R3 chain out disabled", chain_out, 1'b0);

        // R4 operand select
        fall(); defaults(); cfg_xor_sel = XOP_ONE; #1;
        chk("R4 constant one inverts empty sum", pin_o, 1'b1);
        fall(); cfg_xor_sel = XOP_TERM; cfg_pt_role[1] = ROLE_XOR; #1;
        chk("R4 XOR-role term high", pin_o, 1'b1);
        fall(); cfg_lit_true[1][0] = 1'b1; #1;
        chk("R4 XOR-role term low", pin_o, 1'b0);
        fall(); cfg_xor_sel = XOP_ZERO; chain_in = 1'b1; #1;
        chk("R4 constant zero keeps polarity", pin_o, 1'b1);
        fall(); cfg_xor_sel = XOP_ONE; #1;
        chk("R4 constant one flips polarity", pin_o, 1'b0);

        // R5 foldback
        fall(); defaults(); cfg_fb_sel = 3'd2; cfg_lit_true[2][3] = 1'b1; src_in = 8'h08; #1;
        chk("R5 foldback of high term", fold_out, 1'b0);
        fall(); src_in = 8'h00; #1;
        chk("R5 foldback of low term", fold_out, 1'b1);
        fall(); cfg_fb_sel = 3'd4; #1;
        chk("R5 foldback of last term", fold_out, 1'b0);

        // R6 / R7 D element on a global clock
        fall(); defaults(); cfg_reg_out = 1'b1; cfg_ck_src = 2'd1; chain_in = 1'b1; #1;
        chk("R7 no rise yet", pin_o, 1'b0);
        fall(); gclk_lines = 3'b010; #1;
        chk("R7 rise not visible in its own cycle", pin_o, 1'b0);
        fall(); #1;
        chk("R6 D loads on rise", pin_o, 1'b1);
        fall(); chain_in = 1'b0;
        fall(); #1;
        chk("R7 clock held high loads nothing", pin_o, 1'b1);
        fall(); gclk_lines = 3'b000;
        fall(); gclk_lines = 3'b010;
        fall(); #1;
        chk("R6 D loads zero", pin_o, 1'b0);

        // R7 term clock
        fall(); cfg_ck_src = 2'd3; gclk_lines = '0; chain_in = 1'b1;
        cfg_pt_role[0] = ROLE_CLK; cfg_lit_true[0][0] = 1'b1; src_in = 8'h00;
        fall(); src_in = 8'h01;
        fall(); #1;
        chk("R7 CLK-role term clocks storage", pin_o, 1'b1);

        // R8 enable
        fall(); src_in = 8'h00; chain_in = 1'b0;
        cfg_pt_role[3] = ROLE_CE; cfg_lit_true[3][2] = 1'b1;
        fall(); src_in = 8'h01;
        fall(); #1;
        chk("R8 enable low holds", pin_o, 1'b1);
        fall(); src_in = 8'h00;
        fall(); src_in = 8'h05;
        fall(); #1;
        chk("R8 enable high loads", pin_o, 1'b0);

        // R9 preset / clear
        fall(); defaults(); cfg_reg_out = 1'b1;
        cfg_pt_role[4] = ROLE_SET; cfg_lit_true[4][3] = 1'b1; src_in = 8'h08; #1;
        chk("R9 preset acts at once", pin_o, 1'b1);
        fall(); clr_all = 1'b1; #1;
        chk("R9 clear wins over preset", pin_o, 1'b0);
        fall(); clr_all = 1'b0; src_in = 8'h00; #1;
        chk("R9 clear reached stored bit", pin_o, 1'b0);
        fall(); src_in = 8'h08;
        fall(); src_in = 8'h00; #1;
        chk("R9 preset reached stored bit", pin_o, 1'b1);
        fall(); cfg_pt_role[1] = ROLE_CLR; #1;
        chk("R9 CLR-role term clears", pin_o, 1'b0);
        fall(); cfg_pt_role[1] = ROLE_OFF; #1;
        chk("R9 term clear stored", pin_o, 1'b0);

        // R6 T element
        fall(); defaults(); cfg_reg_out = 1'b1; cfg_store_mode = SM_TFF; chain_in = 1'b1;
        fall(); gclk_lines = 3'b001;
        fall(); #1;
        chk("R6 T toggles up", pin_o, 1'b1);
        gclk_lines = 3'b000;
        fall(); gclk_lines = 3'b001;
        fall(); #1;
        chk("R6 T toggles down", pin_o, 1'b0);
        chain_in = 1'b0; gclk_lines = 3'b000;
        fall(); gclk_lines = 3'b001;
        fall(); #1;
        chk("R6 T holds on zero", pin_o, 1'b0);

        // R4 stored-bit operand on a D element
        fall(); cfg_store_mode = SM_DFF; cfg_xor_sel = XOP_STATE; chain_in = 1'b1; gclk_lines = '0;
        fall(); gclk_lines = 3'b001;
        fall(); #1;
        chk("R4 stored-bit operand toggles up", pin_o, 1'b1);
        gclk_lines = 3'b000;
        fall(); gclk_lines = 3'b001;
        fall(); #1;
        chk("R4 stored-bit operand toggles down", pin_o, 1'b0);

        // R6 latch
        fall(); defaults(); cfg_store_mode = SM_LATCH; cfg_reg_out = 1'b1;
        gclk_lines = 3'b001; chain_in = 1'b1; #1;
        chk("R6 latch passes one", pin_o, 1'b1);
        fall(); chain_in = 1'b0; #1;
        chk("R6 latch passes zero", pin_o, 1'b0);
        fall(); chain_in = 1'b1;
        fall(); gclk_lines = 3'b000; #1;
        chk("R6 latch keeps value when closed", pin_o, 1'b1);
        fall(); chain_in = 1'b0; #1;
        chk("R6 closed latch ignores data", pin_o, 1'b1);
        fall(); cfg_reg_out = 1'b0; #1;
        chk("R10 pin shows combinational result", pin_o, 1'b0);

        // R10 output enable
        fall(); defaults(); cfg_oe_src = 3'd3; goe_lines = 6'h08; #1;
        chk("R10 global enable line high", pin_oe, 1'b1);
        fall(); goe_lines = 6'h37; #1;
        chk("R10 global enable line low", pin_oe, 1'b0);
        fall(); cfg_oe_src = 3'd6; #1;
        chk("R10 no OE term gives off", pin_oe, 1'b0);
        fall(); cfg_pt_role[2] = ROLE_OE; cfg_lit_true[2][5] = 1'b1; src_in = 8'h20; #1;
        chk("R10 OE-role term high", pin_oe, 1'b1);
        fall(); src_in = 8'h00; #1;
        chk("R10 OE-role term low", pin_oe, 1'b0);
        fall(); cfg_oe_src = 3'd7; #1;
        chk("R10 always-on code", pin_oe, 1'b1);

        // random phase against the reference
        fall(); rst_n = 1'b0; defaults();
        fall(); fall(); rst_n = 1'b1;
        mn_state = 1'b0; mn_prev = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            fall();
            m_state = mn_state; m_prev = mn_prev;
            if (c % 40 == 0) random_config();
            src_in     = N_IN'($urandom);
            fold_bus   = N_FB'($urandom);
            chain_in   = 1'($urandom);
            gclk_lines = N_GCK'($urandom);
            goe_lines  = N_GOE'($urandom);
            clr_all    = ($urandom % 16 == 0);
            #1;
            model_eval(e_pin, e_oe, e_cas, e_fb, mn_state, mn_prev);
            chk("R10 random pin_o", pin_o, e_pin);
            chk("R10 random pin_oe", pin_oe, e_oe);
            chk("R3 random chain_out", chain_out, e_cas);
            chk("R5 random fold_out", fold_out, e_fb);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule